// File: doc/BRIEF.md
# Line-Sync Interrupt Gate and Composite Sync Mixer

This block sits between a free-running line-sync generator and the CPU and video output stage of a small home computer. A software-written enable flag, set and cleared through two I/O port writes, decides whether each horizontal sync pulse also raises the non-maskable interrupt. The interrupt pulse coincides with the sync pulse to the clock. An external enable pin can override the flag and keep interrupts off. While the interrupt is low and the CPU is not halted, the block asks the CPU to wait, which brings the processor to a known T-state when it enters the interrupt routine.

The block also produces the composite sync output from horizontal sync and the legacy vertical sync, and it blanks video to black for a fixed stretch after each line sync rises, which forms a back porch. While the flag is set, software runs in place of the display. In that state the block drives disable signals to the existing video and sync logic, and it ignores the legacy vertical sync, so stray accesses cannot produce picture glitches or false frame syncs.

Top module: `nmi_sync_mixer`

## Requirements
- R1: A clock edge with `io_wr_n` low and `addr_lo` = 2'b10 (bit 0 low, bit 1 high) sets the enable flag. The flag is visible from the next cycle.
- R2: A clock edge with `io_wr_n` low and `addr_lo` = 2'b01 (bit 1 low, bit 0 high) clears the enable flag.
- R3: A write with `addr_lo` = 2'b00 or 2'b11, and any cycle with `io_wr_n` high, leaves the flag unchanged.
- R4: `nmi_n` is low in exactly those cycles where `hsync` is high, the flag is set and `hw_enable` is high.
- R5: While `hw_enable` is low, `nmi_n` stays high whatever the state of the flag or of `hsync`.
- R6: `sync_n` is low when `hsync` is high, or when `vsync_n` is low and the flag is clear. While the flag is set, `vsync_n` has no effect on `sync_n`.
- R7: `video_disable` and `sync_disable` are both high exactly while the flag is set.
- R8: `wait_n` is low exactly when `halt_n` is high and `nmi_n` is low.
- R9: `video_out` follows `video_in`, but is forced to 0 (black) from the cycle in which `hsync` rises, for PORCH_CYC cycles (default 18), and also for as long as `hsync` stays high. A new rise restarts the interval.
- R10: After a synchronous reset (`rst_n` low at a clock edge) the flag is clear and no blanking interval is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr_n | input | 1 | Combined I/O-request-and-write strobe, active low |
| addr_lo | input | 2 | Low two address bits of the I/O write |
| hw_enable | input | 1 | External interrupt enable pin, high allows interrupts |
| hsync | input | 1 | Horizontal sync pulse from the line generator, active high |
| vsync_n | input | 1 | Legacy vertical sync, active low |
| video_in | input | 1 | Raw video, 1 = white |
| halt_n | input | 1 | CPU halt status, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| wait_n | output | 1 | CPU wait request, active low |
| sync_n | output | 1 | Composite sync, active low |
| video_out | output | 1 | Video with back-porch blanking, 0 = black |
| video_disable | output | 1 | Disable for the existing video generator |
| sync_disable | output | 1 | Disable for the legacy sync generator |

## Verification
The bench writes the two dual-bit addresses that must not change the flag. A decoder that gave either bit priority would flip the flag and turn interrupts on or off at the wrong time. It holds `hw_enable` low with the flag set and `hsync` pulsing, where a missing override would crash software that cannot take interrupts. It counts blanked cycles across a normal sync pulse and across one longer than the porch interval. An off-by-one counter shows up as 17 or 19 black cycles, and a design that ignored the held sync would unblank in the middle of the pulse. It also drives `vsync_n` low with the flag set, where a mixer that failed to gate it would emit a false frame sync.

// File: rtl/nms_pkg.sv
// Shared types and the port-write decode for the sync/interrupt mixer.
// Assumes: only the low two address bits take part in the decode.
package nms_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } flag_cmd_e;

    // Map a strobed write onto a flag command; dual-low or dual-high is a no-op.
    function automatic flag_cmd_e decode_write(input logic wr_n, input logic [1:0] a);
        flag_cmd_e c;
        c = CMD_NONE;
        if (!wr_n) begin
            if (!a[0] && a[1])
                c = CMD_SET;
            else if (!a[1] && a[0])
                c = CMD_CLR;
        end
        return c;
    endfunction

endpackage

// File: rtl/nms_port_latch.sv
// Enable flag written through I/O port writes.
// Assumes: io_wr_n is already synchronous to clk; reset clears the flag.
module nms_port_latch
    import nms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr_n,
    input  logic [1:0] addr_lo,
    output logic       flag
);

    flag_cmd_e cmd;

    // Decode the current bus write into a command.
    always_comb cmd = decode_write(io_wr_n, addr_lo);

    // Hold, set or clear the flag on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (cmd == CMD_SET)
            flag <= 1'b1;
        else if (cmd == CMD_CLR)
            flag <= 1'b0;
    end

endmodule

// File: rtl/nms_porch_timer.sv
// Back-porch blanking: black from the hsync rise for PORCH_CYC cycles
// and while hsync is held. Assumes PORCH_CYC >= 1.
module nms_porch_timer #(
    parameter int PORCH_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    output logic blank
);

    localparam int CW = $clog2(PORCH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PORCH_CYC - 1);

    logic          hs_q;
    logic          rise;
    logic [CW-1:0] cnt;

    // Detect the first cycle of a sync pulse.
    always_comb rise = hsync && !hs_q;

    // Delay hsync and run the remaining-blank countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            cnt  <= '0;
        end else begin
            hs_q <= hsync;
            if (rise)
                cnt <= LOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Blank on the rise, during the countdown and while sync is held.
    always_comb blank = rise || hsync || (cnt != '0);

endmodule

// File: rtl/nms_sync_mix.sv
// Combinational output stage: interrupt gating, wait request, composite
// sync and video gating. Assumes all inputs are synchronous to the clock.
module nms_sync_mix (
    input  logic flag,
    input  logic hw_enable,
    input  logic hsync,
    input  logic vsync_n,
    input  logic halt_n,
    input  logic video_in,
    input  logic blank,
    output logic nmi_n,
    output logic wait_n,
    output logic sync_n,
    output logic video_out
);

    logic nmi_act;

    // Interrupt coincides with sync only when flag and pin both allow it.
    always_comb nmi_act = hsync && flag && hw_enable;

    // Drive the active-low outputs and the gated video.
    always_comb begin
        nmi_n     = !nmi_act;
        wait_n    = !(halt_n && nmi_act);
        sync_n    = !(hsync || (!vsync_n && !flag));
        video_out = video_in && !blank;
    end

endmodule

// File: rtl/nmi_sync_mixer.sv
// Top: line-sync interrupt gate, composite sync mixer and back-porch blanker.
// Assumes hsync comes from an external free-running line generator.
module nmi_sync_mixer #(
    parameter int PORCH_CYC = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr_n,
    input  logic [1:0] addr_lo,
    input  logic       hw_enable,
    input  logic       hsync,
    input  logic       vsync_n,
    input  logic       video_in,
    input  logic       halt_n,
    output logic       nmi_n,
    output logic       wait_n,
    output logic       sync_n,
    output logic       video_out,
    output logic       video_disable,
    output logic       sync_disable
);

    logic flag;
    logic blank;

    nms_port_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr_n (io_wr_n),
        .addr_lo (addr_lo),
        .flag    (flag)
    );

    nms_porch_timer #(.PORCH_CYC(PORCH_CYC)) u_porch (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .blank (blank)
    );

    nms_sync_mix u_mix (
        .flag      (flag),
        .hw_enable (hw_enable),
        .hsync     (hsync),
        .vsync_n   (vsync_n),
        .halt_n    (halt_n),
        .video_in  (video_in),
        .blank     (blank),
        .nmi_n     (nmi_n),
        .wait_n    (wait_n),
        .sync_n    (sync_n),
        .video_out (video_out)
    );

    // Disable the legacy logic while software owns the display time.
    always_comb begin
        video_disable = flag;
        sync_disable  = flag;
    end

endmodule

// File: rtl/nmi_sync_mixer_chk.sv
// Port-level checker for nmi_sync_mixer, attached by bind.
module nmi_sync_mixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_wr_n,
    input logic [1:0] addr_lo,
    input logic       hw_enable,
    input logic       hsync,
    input logic       vsync_n,
    input logic       halt_n,
    input logic       nmi_n,
    input logic       wait_n,
    input logic       sync_n,
    input logic       video_out,
    input logic       video_disable,
    input logic       sync_disable
);

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr_n && addr_lo == 2'b10) |=> video_disable); // R1
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr_n && addr_lo == 2'b01) |=> !video_disable); // R2
    AST_DUAL_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr_n && (addr_lo == 2'b00 || addr_lo == 2'b11)) |=> $stable(video_disable)); // R3
    AST_NMI_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && hw_enable && video_disable) |-> !nmi_n); // R4
    AST_NMI_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n |-> hsync); // R4
    AST_PIN_BLOCKS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_enable |-> nmi_n); // R5
    AST_HSYNC_IN_CSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> !sync_n); // R6
    AST_DISABLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        video_disable == sync_disable); // R7
    AST_WAIT_ON_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_n && !nmi_n) |-> !wait_n); // R8
    AST_BLACK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> !video_out); // R9

endmodule

bind nmi_sync_mixer nmi_sync_mixer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr_n       (io_wr_n),
    .addr_lo       (addr_lo),
    .hw_enable     (hw_enable),
    .hsync         (hsync),
    .vsync_n       (vsync_n),
    .halt_n        (halt_n),
    .nmi_n         (nmi_n),
    .wait_n        (wait_n),
    .sync_n        (sync_n),
    .video_out     (video_out),
    .video_disable (video_disable),
    .sync_disable  (sync_disable)
);

// File: tb/nmi_sync_mixer_tb.sv
// Directed bench: inputs change just after the falling edge, outputs are read 1 ns later.
module nmi_sync_mixer_tb;

    localparam int PORCH = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr_n = 1'b1;
    logic [1:0] addr_lo = 2'b11;
    logic       hw_enable = 1'b1;
    logic       hsync = 1'b0;
    logic       vsync_n = 1'b1;
    logic       video_in = 1'b1;
    logic       halt_n = 1'b1;
    logic       nmi_n, wait_n, sync_n, video_out, video_disable, sync_disable;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    nmi_sync_mixer #(.PORCH_CYC(PORCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr_n(io_wr_n), .addr_lo(addr_lo),
        .hw_enable(hw_enable), .hsync(hsync), .vsync_n(vsync_n),
        .video_in(video_in), .halt_n(halt_n), .nmi_n(nmi_n), .wait_n(wait_n),
        .sync_n(sync_n), .video_out(video_out), .video_disable(video_disable),
        .sync_disable(sync_disable)
    );

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic port_write(input logic [1:0] a);
        step(); io_wr_n = 1'b0; addr_lo = a;
        step(); io_wr_n = 1'b1; addr_lo = 2'b11;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hsync = 1'b1;
        step(); step();
        rst_n = 1'b1; #1;
        chk("R10 nmi_n after reset", nmi_n, 1'b1);
        chk("R10 flag clear after reset", video_disable, 1'b0);
        step(); hsync = 1'b0;
        for (int i = 0; i < PORCH + 2; i++) step();
        #1 chk("R10 no pending blank", video_out, 1'b1);
    endtask

    task automatic t_set_clear();
        port_write(2'b10); #1;
        chk("R1 flag set", video_disable, 1'b1);
        chk("R7 sync_disable set", sync_disable, 1'b1);
        hsync = 1'b1; #1;
        chk("R4 nmi with sync", nmi_n, 1'b0);
        step(); hsync = 1'b0; #1;
        chk("R4 nmi ends with sync", nmi_n, 1'b1);
        port_write(2'b01); #1;
        chk("R2 flag clear", video_disable, 1'b0);
        chk("R7 sync_disable clear", sync_disable, 1'b0);
        hsync = 1'b1; #1;
        chk("R4 no nmi flag clear", nmi_n, 1'b1);
        step(); hsync = 1'b0;
    endtask

    task automatic t_noop_writes();
        port_write(2'b00); #1 chk("R3 00 keeps clear", video_disable, 1'b0);
        port_write(2'b11); #1 chk("R3 11 keeps clear", video_disable, 1'b0);
        port_write(2'b10);
        port_write(2'b00); #1 chk("R3 00 keeps set", video_disable, 1'b1);
        port_write(2'b11); #1 chk("R3 11 keeps set", video_disable, 1'b1);
        step(); addr_lo = 2'b01; step(); step(); #1;
        chk("R3 no strobe keeps set", video_disable, 1'b1);
        addr_lo = 2'b11;
    endtask

    task automatic t_pin();
        hw_enable = 1'b0; hsync = 1'b1; #1;
        chk("R5 pin low blocks nmi", nmi_n, 1'b1);
        chk("R8 no wait without nmi", wait_n, 1'b1);
        step(); hsync = 1'b0; hw_enable = 1'b1;
        step(); hsync = 1'b1; #1;
        chk("R5 pin high allows nmi", nmi_n, 1'b0);
        chk("R8 wait on nmi", wait_n, 1'b0);
        halt_n = 1'b0; #1;
        chk("R8 no wait when halted", wait_n, 1'b1);
        step(); halt_n = 1'b1; hsync = 1'b0;
    endtask

    task automatic t_sync_mix();
        // flag set here: vsync ignored
        vsync_n = 1'b0; #1 chk("R6 vsync ignored with flag", sync_n, 1'b1);
        hsync = 1'b1; #1 chk("R6 hsync with flag", sync_n, 1'b0);
        step(); hsync = 1'b0; vsync_n = 1'b1;
        port_write(2'b01);
        vsync_n = 1'b0; #1 chk("R6 vsync low", sync_n, 1'b0);
        vsync_n = 1'b1; #1 chk("R6 both idle", sync_n, 1'b1);
        hsync = 1'b1; #1 chk("R6 hsync low", sync_n, 1'b0);
        step(); hsync = 1'b0;
        for (int i = 0; i < PORCH + 2; i++) step();
    endtask

    task automatic t_porch(input int width);
        int blanked = 0;
        int exp_n = (width > PORCH) ? width : PORCH;
        for (int i = 0; i < exp_n + 6; i++) begin
            step(); hsync = (i < width); #1;
            if (!video_out) blanked++;
        end
        chk($sformatf("R9 blank count w=%0d (%0d)", width, blanked),
            blanked == exp_n, 1'b1);
        #1 chk("R9 video restored", video_out, 1'b1);
    endtask

    task automatic t_retrigger();
        int blanked = 0;
        for (int i = 0; i < 40; i++) begin
            step(); hsync = (i < 4) || (i >= 10 && i < 14); #1;
            if (!video_out) blanked++;
        end
        chk($sformatf("R9 retrigger count (%0d)", blanked), blanked == 10 + PORCH, 1'b1);
    endtask

    initial begin
        t_reset();
        t_set_clear();
        t_noop_writes();
        t_pin();
        t_sync_mix();
        t_porch(16);
        t_porch(25);
        t_retrigger();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule